// File: doc/BRIEF.md
# Per-Core Inter-Processor Interrupt Register Bank

This block holds the doorbell state that lets one core interrupt another in a multi-core cluster. Each core owns a private bank with an interrupt status word, an enable mask, write-only ports to set and clear status bits, a small mailbox of 32-bit words, and one interrupt line. A core reaches its bank through a shared 32-bit register bus. The bank is chosen by the requester-ID input that travels with the access, not by the address. All cores can therefore use the same offsets.

A core signals another core by writing a send command. The command names a target core and a vector number. One cycle later the block sets that vector bit in the target's status word, with the same interrupt rule as a local set write. If the target number is outside the supported core count, the command has no effect and the block returns a one-cycle error pulse. Mailbox words carry payload between cores. The sender writes the target's mailbox through the target's requester ID, or by an agreed software protocol, and then rings the doorbell.

Top module: `ipi_regfile`

## Requirements
- R1: Only `bus_addr[7:0]` selects a register. The upper address bits have no effect. The bank touched by a read or write is the one numbered by `bus_req_id`.
- R2: The status word reads at offset 0x00 and ignores writes. Offsets 0x08 (set) and 0x0C (clear) read as zero. Every offset that is not decoded reads as zero, and writes to it are dropped.
- R3: A write to 0x08 ORs the data into status. If the resulting status ANDed with the current enable mask is nonzero, the core's interrupt line goes high on the same clock edge.
- R4: A write to 0x0C removes the written bits from status. The line goes low only if status becomes zero while the enable mask is nonzero. In every other case the line keeps its value.
- R5: The enable mask reads and writes at 0x04. An enable write by itself never changes the interrupt line.
- R6: Mailbox word k of the requesting core lives at offset 0x20 + 4k, for k = 0..7. Each word is stored and returned as a full 32-bit value. Every core has its own words.
- R7: A write to offset 0x40 is a send command. The target core is taken from data bits 25:16 and the vector from bits 4:0. One edge after the write, bit `vector` is set in the target's status and the R3 interrupt rule is applied.
- R8: A send whose 10-bit target is greater than or equal to NUM_CORES changes no state. `bus_err` is high for exactly the one cycle after the offending write.
- R9: A send that is being applied and a local set or clear on the same bank in the same cycle are merged. The result is status = (status & ~clear) | set | (1 << vector), so a set bit wins over a clear of the same bit.
- R10: Read data appears on `bus_rdata` in the cycle after `bus_re`. After reset, all status and enable words, `irq_o` and `bus_err` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_req_id | input | CORE_W (2) | Number of the accessing core; selects the bank |
| bus_addr | input | ADDR_W (12) | Byte address; only bits 7:0 are decoded |
| bus_we | input | 1 | Write strobe, one access per cycle |
| bus_re | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data, little-endian word |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_re` |
| bus_err | output | 1 | One-cycle pulse for a send with an out-of-range target |
| irq_o | output | NUM_CORES (4) | Interrupt line per core |

## Verification
A wrong status bit shows up at the ports in two ways. It appears on `bus_rdata` at the first status read after the faulty edge. It can also move `irq_o` one edge after the set or clear that produced it. A faulty enable value is harder to see: it becomes visible only at the next set or clear. For that reason the enable corner cases are exercised with explicit set/clear sequences. A send that was lost, or routed to the wrong bank, appears in the target's status two edges after the command. A send that was wrongly accepted appears either as a missing `bus_err` pulse or as an extra bit in the status of the truncated core number.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int DATA_W = 32;

  // register offsets inside a bank (low address byte)
  localparam logic [7:0] OFF_STATUS = 8'h00;
  localparam logic [7:0] OFF_ENABLE = 8'h04;
  localparam logic [7:0] OFF_SET    = 8'h08;
  localparam logic [7:0] OFF_CLEAR  = 8'h0C;
  localparam logic [7:0] OFF_MBOX   = 8'h20;

  // send command fields
  localparam int TGT_LSB = 16;
  localparam int TGT_W   = 10;
  localparam int VEC_W   = 5;

  typedef enum logic [1:0] {
    SRC_ZERO = 2'd0,
    SRC_REG  = 2'd1,
    SRC_MBOX = 2'd2
  } rd_src_e;

  typedef struct packed {
    logic en_wr;
    logic set_wr;
    logic clr_wr;
    logic mbox_wr;
    logic send_wr;
    logic stat_rd;
    logic en_rd;
    logic mbox_rd;
  } dec_t;

endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
  import ipi_pkg::*;
#(
  parameter int MBOX_WORDS = 8,
  parameter int WORD_W     = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1
) (
  input  logic [7:0]        off_i,
  input  logic              we_i,
  input  logic              re_i,
  output dec_t              dec_o,
  output logic [WORD_W-1:0] word_o
);

  localparam int MBOX_END = int'(OFF_MBOX) + 4 * MBOX_WORDS;
  localparam logic [7:0] OFF_SEND = 8'(MBOX_END);

  logic       in_mbox;
  logic [7:0] rel;

  always_comb begin
    rel     = off_i - OFF_MBOX;
    in_mbox = (off_i >= OFF_MBOX) && (int'(off_i) < MBOX_END);
    word_o  = WORD_W'(rel >> 2);

    dec_o         = '0;
    dec_o.en_wr   = we_i && (off_i == OFF_ENABLE);
    dec_o.set_wr  = we_i && (off_i == OFF_SET);
    dec_o.clr_wr  = we_i && (off_i == OFF_CLEAR);
    dec_o.mbox_wr = we_i && in_mbox;
    dec_o.send_wr = we_i && (off_i == OFF_SEND);
    dec_o.stat_rd = re_i && (off_i == OFF_STATUS);
    dec_o.en_rd   = re_i && (off_i == OFF_ENABLE);
    dec_o.mbox_rd = re_i && in_mbox;
  end

endmodule

// File: rtl/ipi_mailbox.sv
module ipi_mailbox #(
  parameter int DEPTH = 32,
  parameter int AW    = 5,
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          re_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);

  // simple dual-port array, registered read, no reset: RAM friendly
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we_i) mem[waddr_i] <= wdata_i;
    if (re_i) rdata_q <= mem[raddr_i];
  end

  assign rdata_o = rdata_q;

endmodule

// File: rtl/ipi_core_bank.sv
module ipi_core_bank
  import ipi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en_we,
  input  logic [DATA_W-1:0] en_wdata,
  input  logic              set_we,
  input  logic [DATA_W-1:0] set_bits,
  input  logic              clr_we,
  input  logic [DATA_W-1:0] clr_bits,
  output logic [DATA_W-1:0] status_o,
  output logic [DATA_W-1:0] en_o,
  output logic              irq_o
);

  logic [DATA_W-1:0] status_q, en_q, status_nxt;
  logic              irq_q, raise, lower;

  // clear first, then OR in every set source: set wins on a shared bit
  always_comb begin
    status_nxt = (status_q & ~(clr_we ? clr_bits : '0)) | (set_we ? set_bits : '0);
    raise      = set_we && ((status_nxt & en_q) != '0);
    lower      = clr_we && (status_nxt == '0) && (en_q != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      en_q     <= '0;
      irq_q    <= 1'b0;
    end else begin
      status_q <= status_nxt;
      if (en_we) en_q <= en_wdata;
      if (raise)      irq_q <= 1'b1;
      else if (lower) irq_q <= 1'b0;
    end
  end

  assign status_o = status_q;
  assign en_o     = en_q;
  assign irq_o    = irq_q;

  assert_set_sticks_R3: assert property (@(posedge clk) disable iff (rst)
    set_we |=> ((status_o & $past(set_bits)) == $past(set_bits)));

  assert_clear_drops_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_we) |=> ((status_o & $past(clr_bits)) == '0));

  assert_irq_raise_R3: assert property (@(posedge clk) disable iff (rst)
    (set_we && !clr_we && (((status_o | set_bits) & en_o) != '0)) |=> irq_o);

  assert_irq_lower_R4: assert property (@(posedge clk) disable iff (rst)
    (clr_we && !set_we && ((status_o & ~clr_bits) == '0) && (en_o != '0)) |=> !irq_o);

  assert_irq_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (!set_we && !clr_we) |=> $stable(irq_o));

endmodule

// File: rtl/ipi_regfile.sv
module ipi_regfile
  import ipi_pkg::*;
#(
  parameter int NUM_CORES  = 4,
  parameter int MBOX_WORDS = 8,
  parameter int ADDR_W     = 12,
  parameter int CORE_W     = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [CORE_W-1:0]    bus_req_id,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_we,
  input  logic                 bus_re,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 bus_err,
  output logic [NUM_CORES-1:0] irq_o
);

  localparam int  WORD_W  = (MBOX_WORDS > 1) ? $clog2(MBOX_WORDS) : 1;
  localparam int  MB_AW   = CORE_W + WORD_W;
  localparam int  MB_DEPTH = NUM_CORES * MBOX_WORDS;
  localparam bit  ID_FULL = ((1 << CORE_W) == NUM_CORES);
  localparam logic [TGT_W-1:0] TGT_LIMIT = TGT_W'(NUM_CORES);

  // ---------------- decode ----------------
  dec_t              dec;
  logic [WORD_W-1:0] word;
  logic              req_ok;
  logic              unused_addr_hi;

  assign unused_addr_hi = ^bus_addr[ADDR_W-1:8];

  ipi_addr_decode #(.MBOX_WORDS(MBOX_WORDS), .WORD_W(WORD_W)) u_dec (
    .off_i  (bus_addr[7:0]),
    .we_i   (bus_we),
    .re_i   (bus_re),
    .dec_o  (dec),
    .word_o (word)
  );

  generate
    if (ID_FULL) begin : g_id_full
      assign req_ok = 1'b1;
    end else begin : g_id_part
      assign req_ok = (bus_req_id < CORE_W'(NUM_CORES));
    end
  endgenerate

  // ---------------- send command stage ----------------
  logic [TGT_W-1:0]  cmd_tgt;
  logic [VEC_W-1:0]  cmd_vec;
  logic              send_go, send_bad;
  logic              pend_vld_q, err_q;
  logic [CORE_W-1:0] pend_tgt_q;
  logic [VEC_W-1:0]  pend_vec_q;

  assign cmd_tgt  = bus_wdata[TGT_LSB +: TGT_W];
  assign cmd_vec  = bus_wdata[VEC_W-1:0];
  assign send_go  = dec.send_wr && req_ok;
  assign send_bad = send_go && (cmd_tgt >= TGT_LIMIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_vld_q <= 1'b0;
      err_q      <= 1'b0;
      pend_tgt_q <= '0;
      pend_vec_q <= '0;
    end else begin
      pend_vld_q <= send_go && !send_bad;
      err_q      <= send_bad;
      pend_tgt_q <= cmd_tgt[CORE_W-1:0];
      pend_vec_q <= cmd_vec;
    end
  end

  assign bus_err = err_q;

  // ---------------- per-core banks ----------------
  logic [DATA_W-1:0] status_a [NUM_CORES];
  logic [DATA_W-1:0] en_a     [NUM_CORES];

  generate
    for (genvar g = 0; g < NUM_CORES; g++) begin : g_bank
      logic              local_hit, send_hit, set_any;
      logic [DATA_W-1:0] set_vec;

      assign local_hit = req_ok && (bus_req_id == CORE_W'(g));
      assign send_hit  = pend_vld_q && (pend_tgt_q == CORE_W'(g));
      assign set_any   = (local_hit && dec.set_wr) || send_hit;
      assign set_vec   = ((local_hit && dec.set_wr) ? bus_wdata : '0)
                       | (send_hit ? (DATA_W'(1) << pend_vec_q) : '0);

      ipi_core_bank u_bank (
        .clk      (clk),
        .rst      (rst),
        .en_we    (local_hit && dec.en_wr),
        .en_wdata (bus_wdata),
        .set_we   (set_any),
        .set_bits (set_vec),
        .clr_we   (local_hit && dec.clr_wr),
        .clr_bits (bus_wdata),
        .status_o (status_a[g]),
        .en_o     (en_a[g]),
        .irq_o    (irq_o[g])
      );
    end
  endgenerate

  // ---------------- mailbox ----------------
  logic [MB_AW-1:0]  mb_addr;
  logic [DATA_W-1:0] mb_rdata;

  assign mb_addr = {bus_req_id, word};

  ipi_mailbox #(.DEPTH(MB_DEPTH), .AW(MB_AW), .DW(DATA_W)) u_mbox (
    .clk     (clk),
    .we_i    (dec.mbox_wr && req_ok),
    .waddr_i (mb_addr),
    .wdata_i (bus_wdata),
    .re_i    (dec.mbox_rd && req_ok),
    .raddr_i (mb_addr),
    .rdata_o (mb_rdata)
  );

  // ---------------- read return ----------------
  rd_src_e           src_q;
  logic [DATA_W-1:0] reg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      src_q <= SRC_ZERO;
      reg_q <= '0;
    end else if (bus_re) begin
      if (!req_ok)                   src_q <= SRC_ZERO;
      else if (dec.mbox_rd)          src_q <= SRC_MBOX;
      else if (dec.stat_rd || dec.en_rd) src_q <= SRC_REG;
      else                           src_q <= SRC_ZERO;
      reg_q <= dec.stat_rd ? status_a[bus_req_id] :
               dec.en_rd   ? en_a[bus_req_id] : '0;
    end
  end

  always_comb begin
    case (src_q)
      SRC_MBOX: bus_rdata = mb_rdata;
      SRC_REG:  bus_rdata = reg_q;
      default:  bus_rdata = '0;
    endcase
  end

  // ---------------- checks ----------------
  assert_dec_onehot_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({dec.en_wr, dec.set_wr, dec.clr_wr, dec.mbox_wr, dec.send_wr}));

  assert_err_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    send_bad |=> (bus_err && !pend_vld_q));

  assert_err_cause_R8: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(send_bad));

  assert_rd_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (bus_re && !dec.stat_rd && !dec.en_rd && !dec.mbox_rd) |=> (bus_rdata == '0));

endmodule

// File: tb/sim_ipi_regfile.sv
`timescale 1ns/1ps
module sim_ipi_regfile;

  logic        clk = 1'b0;
  logic        rst;
  logic [1:0]  req;
  logic [11:0] addr;
  logic        we, re;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        err;
  logic [3:0]  irq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  ipi_regfile u0 (
    .clk(clk), .rst(rst), .bus_req_id(req), .bus_addr(addr),
    .bus_we(we), .bus_re(re), .bus_wdata(wdata),
    .bus_rdata(rdata), .bus_err(err), .irq_o(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [1:0]  rq;
    logic [11:0] ad;
    logic [31:0] dt;
    logic [31:0] ex;
    logic [7:0]  tag;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 2'd0, 12'h004, 32'hFFFF_FFFF, 32'h0,         8'd5},  // R5 enable
    '{1'b1, 2'd0, 12'h008, 32'h0000_00A5, 32'h0,         8'd3},  // R3 set
    '{1'b0, 2'd0, 12'h000, 32'h0,         32'h0000_00A5, 8'd3},
    '{1'b0, 2'd0, 12'h008, 32'h0,         32'h0,         8'd2},  // R2 set reads 0
    '{1'b0, 2'd0, 12'h00C, 32'h0,         32'h0,         8'd2},  // R2 clear reads 0
    '{1'b1, 2'd0, 12'h00C, 32'h0000_0005, 32'h0,         8'd4},  // R4 clear
    '{1'b0, 2'd0, 12'h000, 32'h0,         32'h0000_00A0, 8'd4},
    '{1'b1, 2'd0, 12'h000, 32'h0000_FFFF, 32'h0,         8'd2},  // R2 status write
    '{1'b0, 2'd0, 12'h000, 32'h0,         32'h0000_00A0, 8'd2},
    '{1'b0, 2'd0, 12'h004, 32'h0,         32'hFFFF_FFFF, 8'd5},
    '{1'b1, 2'd2, 12'h020, 32'h1111_2222, 32'h0,         8'd6},  // R6 mailbox
    '{1'b1, 2'd2, 12'h03C, 32'hDEAD_BEEF, 32'h0,         8'd6},
    '{1'b1, 2'd1, 12'h020, 32'h0000_0055, 32'h0,         8'd1},  // R1 other bank
    '{1'b0, 2'd2, 12'h020, 32'h0,         32'h1111_2222, 8'd6},
    '{1'b0, 2'd2, 12'h03C, 32'h0,         32'hDEAD_BEEF, 8'd6},
    '{1'b0, 2'd1, 12'h020, 32'h0,         32'h0000_0055, 8'd1},
    '{1'b0, 2'd2, 12'hF20, 32'h0,         32'h1111_2222, 8'd1},  // R1 high bits
    '{1'b0, 2'd0, 12'h010, 32'h0,         32'h0,         8'd2},  // R2 undecoded
    '{1'b0, 2'd1, 12'h000, 32'h0,         32'h0,         8'd1},
    '{1'b0, 2'd0, 12'hD00, 32'h0,         32'h0000_00A0, 8'd1}
  };

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %08h expected %08h", rq, act, exp);
    end
  endtask

  // caller is at a negedge; returns at the next negedge
  task automatic bus_write(input logic [1:0] r, input logic [11:0] a, input logic [31:0] d);
    req = r; addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] r, input logic [11:0] a, output logic [31:0] d);
    req = r; addr = a; re = 1'b1;
    @(negedge clk);
    re = 1'b0;
    d = rdata;
  endtask

  task automatic idle();
    @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hang expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst = 1'b1; req = '0; addr = '0; we = 1'b0; re = 1'b0; wdata = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R10 reset state
    chk("R10", {28'b0, irq}, 32'h0);
    chk("R10", {31'b0, err}, 32'h0);
    for (int c = 0; c < 4; c++) begin
      bus_read(2'(c), 12'h000, d);
      chk("R10", d, 32'h0);
    end
    bus_read(2'd1, 12'h004, d);
    chk("R10", d, 32'h0);

    // vector table
    for (int i = 0; i < NV; i++) begin
      if (VEC[i].wr) bus_write(VEC[i].rq, VEC[i].ad, VEC[i].dt);
      else begin
        bus_read(VEC[i].rq, VEC[i].ad, d);
        chk($sformatf("R%0d", VEC[i].tag), d, VEC[i].ex);
      end
    end

    // R3: core0 line high since set with full enable
    chk("R3", {31'b0, irq[0]}, 32'h1);
    // R4: clearing everything with enable nonzero drops the line
    bus_write(2'd0, 12'h00C, 32'h0000_00A0);
    chk("R4", {31'b0, irq[0]}, 32'h0);

    // R5/R4: enable changes do not move the line; clear with zero enable keeps it
    bus_write(2'd3, 12'h004, 32'h1);
    bus_write(2'd3, 12'h008, 32'h1);
    chk("R3", {31'b0, irq[3]}, 32'h1);
    bus_write(2'd3, 12'h004, 32'h0);
    chk("R5", {31'b0, irq[3]}, 32'h1);
    bus_write(2'd3, 12'h00C, 32'h1);
    chk("R4", {31'b0, irq[3]}, 32'h1);
    bus_read(2'd3, 12'h000, d);
    chk("R4", d, 32'h0);
    bus_write(2'd3, 12'h004, 32'h2);
    bus_write(2'd3, 12'h00C, 32'h0);
    chk("R4", {31'b0, irq[3]}, 32'h0);

    // R4: partial clear keeps the line high
    bus_write(2'd0, 12'h008, 32'h3);
    bus_write(2'd0, 12'h00C, 32'h1);
    chk("R4", {31'b0, irq[0]}, 32'h1);
    bus_read(2'd0, 12'h000, d);
    chk("R4", d, 32'h2);

    // R7: send from core0 to core1 vector 7
    bus_write(2'd0, 12'h040, 32'h0001_0007);
    chk("R8", {31'b0, err}, 32'h0);
    idle();
    bus_read(2'd1, 12'h000, d);
    chk("R7", d, 32'h0000_0080);
    chk("R7", {31'b0, irq[1]}, 32'h0);

    // R8: out-of-range targets
    bus_write(2'd0, 12'h040, 32'h0004_0002);
    chk("R8", {31'b0, err}, 32'h1);
    idle();
    chk("R8", {31'b0, err}, 32'h0);
    bus_read(2'd0, 12'h000, d);
    chk("R8", d, 32'h2);
    bus_write(2'd2, 12'h040, 32'h03FF_0001);
    chk("R8", {31'b0, err}, 32'h1);
    idle();
    bus_read(2'd3, 12'h000, d);
    chk("R8", d, 32'h0);

    // R9: send applied together with a local set on the same bank
    bus_write(2'd0, 12'h040, 32'h0001_0003);
    bus_write(2'd1, 12'h008, 32'h0000_0010);
    bus_read(2'd1, 12'h000, d);
    chk("R9", d, 32'h0000_0098);
    // R9: send applied together with a local clear; the set bit survives
    bus_write(2'd0, 12'h040, 32'h0001_0000);
    bus_write(2'd1, 12'h00C, 32'h0000_0099);
    bus_read(2'd1, 12'h000, d);
    chk("R9", d, 32'h0000_0001);

    // R7: a send raises the target line one edge after the command
    bus_write(2'd2, 12'h004, 32'h0000_0100);
    bus_write(2'd0, 12'h040, 32'h0002_0008);
    chk("R7", {31'b0, irq[2]}, 32'h0);
    idle();
    chk("R7", {31'b0, irq[2]}, 32'h1);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule